// File: doc/BRIEF.md
# Directly Decoded Accumulator Processor

This block is a very small accumulator processor. Its opcode needs almost no decoding: the low three opcode bits pick the datapath result directly, and the top opcode bit marks a jump. Each 16-bit instruction carries a 4-bit opcode and a 12-bit immediate. The immediate supplies a literal, a data-memory address or a jump target. For the logic instruction, its top two bits also choose the operator.

Every instruction finishes in one clock cycle. The core holds a program counter, an accumulator, a one-entry return register for call and return, and a zero detector on the accumulator. A few opcode patterns are recognised explicitly: unconditional jump, call, return and no-operation. They switch off the accumulator write and the memory write, and they steer the program counter.

The instruction memory and the data memory are internal arrays. While `run` is low, the core is frozen and the arrays can be loaded and read through the load ports. While `run` is high, the core executes one instruction per cycle.

Top module: `ddp_core`

## Requirements
- R1: After reset the program counter, the accumulator and the return register are all zero. A return executed first after reset goes to address 0.
- R2: An instruction has the opcode in bits 15:12 and the immediate in bits 11:0. Bit 15 is the jump bit and bits 14:12 select the result.
- R2 (continued): The result encodings are:
  - 000: keep the accumulator.
  - 001: load the immediate.
  - 010: add the immediate.
  - 011: load the memory word.
  - 100: add the memory word.
  - 101: subtract the memory word.
  - 110: logic operation.
  - 111: store.
- R2 (continued): Memory operands use the address in immediate bits 3:0. All arithmetic wraps modulo 2^12.
- R3: Opcode 0110 combines the accumulator with the memory word at immediate bits 3:0. Immediate bits 11:10 pick the operator: 00 AND, 01 OR, 10 XOR, 11 shift the accumulator left by one.
- R4: Opcode 0111 writes the accumulator into data memory at immediate bits 3:0 and leaves the accumulator unchanged.
- R5: When no jump, call or return is taken, the program counter advances by one each running cycle and wraps from 63 to 0.
- R6: Opcodes 1000 to 1011 update the accumulator as their low three bits select. They jump to immediate bits 5:0 only if the accumulator was zero before the instruction; otherwise the program counter advances by one.
- R7: Opcode 1100 jumps to immediate bits 5:0 whatever the accumulator holds, and writes neither the accumulator nor memory.
- R8: Opcode 1110 (call) saves the program counter plus one in the return register and jumps to immediate bits 5:0. Opcode 1101 (return) loads the program counter from the return register. Neither writes the accumulator.
- R9: Opcode 1111 (no-operation) writes neither the accumulator nor memory, even though its low bits select store, and advances the program counter by one.
- R10: While `run` is low, the program counter and the accumulator hold. The load ports write the arrays, and `data_rdata` shows the data word at `data_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Core clock enable; low freezes the core and hands the arrays to the load ports |
| prog_we | input | 1 | Instruction array write strobe |
| prog_addr | input | PC_W | Instruction array write address |
| prog_data | input | 16 | Instruction word to write |
| data_we | input | 1 | Data array write strobe (used while `run` is low) |
| data_addr | input | DADDR_W | Data array address for load and inspection |
| data_wdata | input | DATA_W | Data word to write |
| data_rdata | output | DATA_W | Data word at `data_addr` while `run` is low |
| pc_o | output | PC_W | Program counter |
| acc_o | output | DATA_W | Accumulator |

## Verification
Some properties are checked by assertions on every cycle:
- the program counter step after a non-branching instruction;
- the target of unconditional jumps, calls and returns;
- the link value a call saves;
- the freeze while `run` is low;
- the accumulator left untouched by store and no-operation;
- the literal load.

Only the bench's scenarios can show the rest. These are the actual arithmetic and logic results of each operator against the memory contents, whether a conditional jump is taken as the accumulator moves through zero, the counter wrapping at the top of the instruction space, and the memory contents left behind by store and by the suppressed store of the no-operation.

// File: rtl/ddp_pkg.sv
package ddp_pkg;
  localparam int INSTR_W = 16;
  localparam int OP_W    = 4;
  localparam int IMM_W   = INSTR_W - OP_W;

  // low three opcode bits are the result select, no table between
  typedef enum logic [2:0] {
    SEL_ACC   = 3'd0,
    SEL_IMM   = 3'd1,
    SEL_ADDI  = 3'd2,
    SEL_LDM   = 3'd3,
    SEL_ADDM  = 3'd4,
    SEL_SUBM  = 3'd5,
    SEL_LOGIC = 3'd6,
    SEL_STORE = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2,
    LOG_SHL = 2'd3
  } log_e;

  localparam logic [OP_W-1:0] OP_JMP  = 4'hC;
  localparam logic [OP_W-1:0] OP_RET  = 4'hD;
  localparam logic [OP_W-1:0] OP_CALL = 4'hE;
  localparam logic [OP_W-1:0] OP_NOP  = 4'hF;
endpackage

// File: rtl/ddp_ram.sv
module ddp_ram #(
  parameter int WIDTH = 16,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ddp_decode.sv
module ddp_decode
  import ddp_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output sel_e            sel,
  output logic            acc_we,
  output logic            mem_we,
  output logic            jcond,
  output logic            uncond,
  output logic            is_call,
  output logic            is_ret
);
  logic special;
  logic is_nop;

  always_comb begin
    sel     = sel_e'(opcode[2:0]);
    special = opcode[3] & opcode[2];
    is_nop  = (opcode == OP_NOP);
    uncond  = (opcode == OP_JMP);
    is_call = (opcode == OP_CALL);
    is_ret  = (opcode == OP_RET);
    jcond   = opcode[3] & ~opcode[2];
    acc_we  = ~special;
    mem_we  = (sel == SEL_STORE) & ~is_nop;
  end
endmodule

// File: rtl/ddp_alu.sv
module ddp_alu
  import ddp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  sel_e              sel,
  input  logic [DATA_W-1:0] acc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] logic_res;
  log_e              lop;

  always_comb begin
    imm_ext = DATA_W'(imm);
    lop     = log_e'(imm[IMM_W-1 -: 2]);
    case (lop)
      LOG_AND: logic_res = acc & mem_word;
      LOG_OR:  logic_res = acc | mem_word;
      LOG_XOR: logic_res = acc ^ mem_word;
      default: logic_res = {acc[DATA_W-2:0], 1'b0};
    endcase
  end

  always_comb begin
    case (sel)
      SEL_IMM:   result = imm_ext;
      SEL_ADDI:  result = acc + imm_ext;
      SEL_LDM:   result = mem_word;
      SEL_ADDM:  result = acc + mem_word;
      SEL_SUBM:  result = acc - mem_word;
      SEL_LOGIC: result = logic_res;
      default:   result = acc;
    endcase
  end
endmodule

// File: rtl/ddp_seq.sv
module ddp_seq #(
  parameter int PC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            jcond,
  input  logic            zero,
  input  logic            uncond,
  input  logic            is_call,
  input  logic            is_ret,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] ret_q, ret_d;
  logic [PC_W-1:0] pc_inc;

  always_comb begin
    pc_inc = pc_q + PC_W'(1);
    pc_d   = pc_q;
    ret_d  = ret_q;
    if (run) begin
      if (uncond || is_call || (jcond && zero)) begin
        pc_d = target;
      end else if (is_ret) begin
        pc_d = ret_q;
      end else begin
        pc_d = pc_inc;
      end
      if (is_call) begin
        ret_d = pc_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ret_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ret_q <= ret_d;
    end
  end

  assign pc = pc_q;

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && !uncond && !is_call && !is_ret && !(jcond && zero)
      |=> pc_q == $past(pc_q) + PC_W'(1));

  assert_uncond_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && uncond |=> pc_q == $past(target));

  assert_call_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && is_call |=> (ret_q == $past(pc_q) + PC_W'(1)) && (pc_q == $past(target)));

  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && is_ret |=> pc_q == $past(ret_q));

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc_q) && $stable(ret_q));
endmodule

// File: rtl/ddp_core.sv
module ddp_core
  import ddp_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int PC_W    = 6,
  parameter int DADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               prog_we,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               data_we,
  input  logic [DADDR_W-1:0] data_addr,
  input  logic [DATA_W-1:0]  data_wdata,
  output logic [DATA_W-1:0]  data_rdata,
  output logic [PC_W-1:0]    pc_o,
  output logic [DATA_W-1:0]  acc_o
);
  logic [INSTR_W-1:0] instr;
  logic [OP_W-1:0]    opcode;
  logic [IMM_W-1:0]   imm;
  sel_e               sel;
  logic               acc_we, mem_we, jcond, uncond, is_call, is_ret;
  logic               zero;
  logic [DATA_W-1:0]  acc_q, acc_d, result;
  logic [PC_W-1:0]    pc;
  logic               dm_we;
  logic [DADDR_W-1:0] dm_addr;
  logic [DATA_W-1:0]  dm_wdata, dm_rdata;

  ddp_ram #(.WIDTH(INSTR_W), .AW(PC_W)) u_imem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc), .rdata(instr)
  );

  assign opcode = instr[INSTR_W-1 -: OP_W];
  assign imm    = instr[IMM_W-1:0];

  ddp_decode u_dec (
    .opcode(opcode), .sel(sel), .acc_we(acc_we), .mem_we(mem_we),
    .jcond(jcond), .uncond(uncond), .is_call(is_call), .is_ret(is_ret)
  );

  // data array belongs to the core while running, to the load port otherwise
  always_comb begin
    if (run) begin
      dm_we    = mem_we;
      dm_addr  = imm[DADDR_W-1:0];
      dm_wdata = acc_q;
    end else begin
      dm_we    = data_we;
      dm_addr  = data_addr;
      dm_wdata = data_wdata;
    end
  end

  ddp_ram #(.WIDTH(DATA_W), .AW(DADDR_W)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_addr), .wdata(dm_wdata),
    .raddr(dm_addr), .rdata(dm_rdata)
  );

  ddp_alu #(.DATA_W(DATA_W)) u_alu (
    .sel(sel), .acc(acc_q), .imm(imm), .mem_word(dm_rdata), .result(result)
  );

  assign zero = (acc_q == '0);

  ddp_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .jcond(jcond), .zero(zero),
    .uncond(uncond), .is_call(is_call), .is_ret(is_ret),
    .target(imm[PC_W-1:0]), .pc(pc)
  );

  always_comb begin
    acc_d = acc_q;
    if (run && acc_we) begin
      acc_d = result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign data_rdata = dm_rdata;
  assign pc_o       = pc;
  assign acc_o      = acc_q;

  assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(acc_q));

  assert_nop_keeps_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && opcode == OP_NOP |=> $stable(acc_q));

  assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && opcode == 4'h7 |=> $stable(acc_q));

  assert_load_literal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && opcode == 4'h1 |=> acc_q == DATA_W'($past(imm)));

  assert_special_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && (is_call || is_ret || uncond) |=> $stable(acc_q));
endmodule

// File: tb/ddp_core_bench.sv
`timescale 1ns/1ps
module ddp_core_bench;
  localparam int DW = 12;
  localparam int PW = 6;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          prog_we = 1'b0;
  logic [PW-1:0] prog_addr = '0;
  logic [15:0]   prog_data = '0;
  logic          data_we = 1'b0;
  logic [AW-1:0] data_addr = '0;
  logic [DW-1:0] data_wdata = '0;
  logic [DW-1:0] data_rdata;
  logic [PW-1:0] pc_o;
  logic [DW-1:0] acc_o;

  ddp_core u_ddp_core (
    .clk(clk), .rst_n(rst_n), .run(run), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data), .data_we(data_we),
    .data_addr(data_addr), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .pc_o(pc_o), .acc_o(acc_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0]   m_imem [64];
  logic [DW-1:0] m_dmem [16];
  logic [PW-1:0] m_pc, m_ret;
  logic [DW-1:0] m_acc;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] op);
    if (op == 4'h7) return "R4";
    if (op == 4'h6) return "R3";
    if (op[3] == 1'b0) return "R2";
    if (op[2] == 1'b0) return "R6";
    if (op == 4'hC) return "R7";
    if (op == 4'hF) return "R9";
    return "R8";
  endfunction

  task automatic put_prog(int a, logic [15:0] v);
    prog_we = 1'b1; prog_addr = PW'(a); prog_data = v;
    m_imem[a] = v;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_acc = '0; m_ret = '0;
    @(negedge clk);
  endtask

  // bench model of one instruction, then one running cycle of the design
  task automatic step();
    logic [15:0]   ins = m_imem[m_pc];
    logic [3:0]    op = ins[15:12];
    logic [11:0]   imm = ins[11:0];
    logic [DW-1:0] md = m_dmem[imm[3:0]];
    logic [DW-1:0] r;
    logic          z = (m_acc == 0);
    logic          spec = op[3] & op[2];
    logic [PW-1:0] nxt = m_pc + 1'b1;
    case (op[2:0])
      3'd1: r = imm;
      3'd2: r = DW'(m_acc + imm);
      3'd3: r = md;
      3'd4: r = DW'(m_acc + md);
      3'd5: r = DW'(m_acc - md);
      3'd6: case (imm[11:10])
              2'd0: r = m_acc & md;
              2'd1: r = m_acc | md;
              2'd2: r = m_acc ^ md;
              default: r = DW'({m_acc, 1'b0});
            endcase
      default: r = m_acc;
    endcase
    if (op == 4'h7) m_dmem[imm[3:0]] = m_acc;
    if (spec) begin
      if (op == 4'hC) nxt = imm[5:0];
      else if (op == 4'hD) nxt = m_ret;
      else if (op == 4'hE) begin m_ret = m_pc + 1'b1; nxt = imm[5:0]; end
    end else begin
      m_acc = r;
      if (op[3] && z) nxt = imm[5:0];
    end
    m_pc = nxt;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    check(tag_of(op), "acc", acc_o, m_acc);
    check((op[3] && !(op == 4'hF)) ? tag_of(op) : "R5", "pc", pc_o, m_pc);
  endtask

  task automatic check_dmem(string req);
    for (int a = 0; a < 16; a++) begin
      data_addr = AW'(a);
      #1;
      check(req, "dmem", data_rdata, m_dmem[a]);
    end
  endtask

  localparam logic [11:0] IMMS [8] = '{12'h000, 12'h001, 12'h02A, 12'h3C7,
                                       12'h40B, 12'h80E, 12'hC03, 12'hFFF};
  localparam logic [11:0] ACCS [3] = '{12'h000, 12'h005, 12'hFFF};

  initial begin
    for (int i = 0; i < 64; i++) m_imem[i] = 16'hF000;
    @(negedge clk);
    do_reset();
    check("R1", "reset pc", pc_o, 0);
    check("R1", "reset acc", acc_o, 0);
    for (int i = 0; i < 64; i++) put_prog(i, 16'hF000);
    // R10: preload data array through the load port while stopped
    for (int a = 0; a < 16; a++) begin
      data_we = 1'b1; data_addr = AW'(a); data_wdata = DW'(a * 273 + 7);
      m_dmem[a] = DW'(a * 273 + 7);
      @(negedge clk);
    end
    data_we = 1'b0;
    check_dmem("R10");

    // sweep every opcode over accumulator and immediate patterns
    for (int op = 0; op < 16; op++) begin
      for (int ai = 0; ai < 3; ai++) begin
        for (int ii = 0; ii < 8; ii++) begin
          put_prog(0, {4'h1, ACCS[ai]});
          put_prog(1, {4'(op), IMMS[ii]});
          do_reset();
          check("R1", "pc after reset", pc_o, 0);
          step();
          step();
        end
      end
    end
    check_dmem("R4");

    // R8: call then return, R9 no-op, R4 store
    put_prog(0, 16'h1123);
    put_prog(1, 16'hE009);
    put_prog(9, 16'h2001);
    put_prog(10, 16'hD000);
    put_prog(2, 16'h7003);
    put_prog(3, 16'hF005);
    put_prog(4, 16'h8020);
    do_reset();
    for (int s = 0; s < 7; s++) step();
    check("R8", "pc after call-return path", pc_o, 5);
    check_dmem("R9");

    // R6: zero accumulator takes the conditional jump, nonzero does not
    put_prog(0, 16'h1000);
    put_prog(1, 16'h8010);
    put_prog(16, 16'h1004);
    put_prog(17, 16'h8030);
    do_reset();
    for (int s = 0; s < 4; s++) step();
    check("R6", "not taken with nonzero acc", pc_o, 18);

    // R5: wrap from the top of the instruction space
    put_prog(0, 16'hC03F);
    put_prog(63, 16'h2002);
    do_reset();
    for (int s = 0; s < 3; s++) step();

    // R10: stopped core holds its state
    for (int s = 0; s < 5; s++) @(negedge clk);
    check("R10", "pc held", pc_o, m_pc);
    check("R10", "acc held", acc_o, m_acc);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule